// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that follows a chain of descriptors held in memory. It moves bytes between memory buffers and a device-side byte stream. Each descriptor is three consecutive 32-bit words: the buffer start address first, then a count/flags word, then the address of the following descriptor. The channel reads each descriptor through a word-wide memory request port. It then sends the buffer's bytes out on a transmit stream, or gathers bytes from a receive stream and writes them into the buffer. When a buffer is finished, the channel writes an updated count/flags word back to the descriptor. It then moves on to the next descriptor, or stops if that descriptor ends the chain.

Software uses a small register interface. It loads the first descriptor address, starts the channel with the direction and byte order it wants, and polls a status word. That status word carries a sticky interrupt flag, which clears when the status is read.

Both byte streams use valid/ready. A transmit beat completes on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady. A receive beat completes when `rx_valid` and `rx_ready` are both high. The channel drops `rx_ready` while it writes a gathered word to memory.

On the memory port, a request (`mem_req` with its address, data, byte enables and `mem_we`) is held unchanged until a cycle with `mem_ack`. On a read, `mem_rdata` is taken in that acknowledge cycle.

Top module: `chdma_top`

## Requirements
- R1: After reset the channel is idle. `irq`, `mem_req`, `tx_valid` and `rx_ready` are low, and the status, next-descriptor and current-pointer registers all read zero.
- R2: A write to the control register (address 0) starts an idle channel only when bit 4 and bit 5 are both set in that write. A write with only one of them set leaves the channel idle and issues no memory request.
- R3: For the descriptor at address P, the channel reads P, then P+4, then P+8. These words are the buffer address, the count/flags word and the next-descriptor address.
- R4: In transmit mode (control bit 2 clear when starting), the channel sends the bytes of the buffer in rising address order. The byte count is bits 13:0 of the count/flags word, and the start address may be unaligned. With control bit 1 clear, the byte at word offset 0 is taken from bits 31:24 of the memory word. With control bit 1 set, the bytes within each word are reversed, so offset 0 comes from bits 7:0.
- R5: `tx_last` is high with the final byte of a buffer whose count/flags bit 30 is set, and is low on every other beat.
- R6: In receive mode (control bit 2 set when starting), received bytes are written into the buffer in rising address order. They use the same byte-lane mapping as R4. Only the lanes actually received are enabled on each word write.
- R7: After a buffer is finished, the count/flags word is written back to P+4 with all other bits unchanged. Transmit sets bit 15. Receive clears bit 14, the ownership bit, to hand the buffer back to software.
- R8: If bit 31 of the count/flags word is clear, the channel goes on to the descriptor at the next-descriptor address. If bit 31 is set, the channel goes idle after the write-back. After going idle, the next-descriptor register holds the last descriptor's next field.
- R9: If bit 29 is set, completing that descriptor sets the interrupt flag. The flag drives `irq` and reads as status bit 0, with status bit 1 showing the channel active. A read of the status register returns the flag and then clears it.
- R10: A count of zero moves no data and reads no buffer word, but the write-back, interrupt and end-of-chain handling still take place.
- R11: The current-pointer register (address 2) reads the buffer address plus the number of bytes moved so far. The next-descriptor register (address 1) can be written only while the channel is idle; writes while it is active are ignored.
- R12: A stalled transmit beat keeps its data and flag stable until accepted. A memory request keeps its address and direction until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe (a status read clears the interrupt flag) |
| csr_addr | input | 2 | Register select: 0 control/status, 1 next descriptor, 2 current pointer |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational from `csr_addr` |
| irq | output | 1 | Interrupt flag |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for a write, one per 8-bit lane |
| mem_ack | input | 1 | Request completion; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Device accepts the transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Transmit byte ends a packet |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Channel accepts the receive byte |
| rx_data | input | 8 | Receive byte |

## Verification
Single-descriptor transmit runs cover several lengths, from one byte to eight, at every start offset within a word. They use both byte orders, with the device either always ready or ready on alternate cycles. These runs separate a wrong lane order, a miscounted length, an end-of-packet mark on the wrong byte, and a failure to refetch after a word boundary.

A three-descriptor chain holds a zero-length middle entry. It starts with the device stalled, which exposes stream hold behaviour, ignored pointer writes, fetch order and the zero-count path. Two receive runs, one unaligned in big-endian order and one aligned in little-endian order, show whether lanes are placed and enabled correctly and whether the ownership bit is cleared.

// File: rtl/chdma_pkg.sv
package chdma_pkg;
  localparam int WORD_W = 32;

  // count/flags word
  localparam int F_EOC  = 31;
  localparam int F_EOP  = 30;
  localparam int F_IE   = 29;
  localparam int F_DONE = 15;
  localparam int F_OWN  = 14;

  // control write bits
  localparam int C_LE = 1;
  localparam int C_RX = 2;
  localparam int C_GO = 4;
  localparam int C_LD = 5;

  // status read bits
  localparam int S_IRQ = 0;
  localparam int S_ACT = 1;

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_NEXT = 2'd1;
  localparam logic [1:0] A_CUR  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BUF, ST_INFO, ST_NEXT, ST_XFER, ST_WB
  } phase_t;
endpackage

// File: rtl/chdma_lane.sv
module chdma_lane
  import chdma_pkg::*;
#(
  parameter int LANES = WORD_W / 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [LW-1:0]     lane,
  input  logic              little,
  input  logic [7:0]        byte_in,
  output logic [7:0]        byte_out,
  output logic [WORD_W-1:0] word_out,
  output logic [LANES-1:0]  be_out
);
  logic [LW-1:0] idx;

  // big-endian puts the lowest address in the top lane
  assign idx      = little ? lane : ~lane;
  assign byte_out = word_in[{idx, 3'b000} +: 8];
  assign word_out = WORD_W'(byte_in) << {idx, 3'b000};
  assign be_out   = LANES'(1) << idx;
endmodule

// File: rtl/chdma_csr.sv
module chdma_csr
  import chdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [1:0]        csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  input  logic              active,
  input  logic              irq_set,
  input  logic [WORD_W-1:0] desc_ptr,
  input  logic [WORD_W-1:0] cur_ptr,
  output logic              start,
  output logic              little,
  output logic              rx_mode,
  output logic              next_wr,
  output logic              irq
);
  logic [WORD_W-1:0] status;

  assign start   = csr_wr && csr_addr == A_CTL && csr_wdata[C_GO] && csr_wdata[C_LD] && !active;
  assign next_wr = csr_wr && csr_addr == A_NEXT && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      little  <= 1'b0;
      rx_mode <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (start) begin
        little  <= csr_wdata[C_LE];
        rx_mode <= csr_wdata[C_RX];
      end
      if (irq_set)
        irq <= 1'b1;
      else if (csr_rd && csr_addr == A_CTL)
        irq <= 1'b0;
    end
  end

  always_comb begin
    status        = '0;
    status[S_IRQ] = irq;
    status[S_ACT] = active;
    case (csr_addr)
      A_CTL:   csr_rdata = status;
      A_NEXT:  csr_rdata = desc_ptr;
      A_CUR:   csr_rdata = cur_ptr;
      default: csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/chdma_core.sv
module chdma_core
  import chdma_pkg::*;
#(
  parameter int CNT_W = 14,
  localparam int LANES = WORD_W / 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              little,
  input  logic              rx_mode,
  input  logic              next_wr,
  input  logic [WORD_W-1:0] next_wdata,
  output logic [WORD_W-1:0] desc_ptr,
  output logic [WORD_W-1:0] cur_ptr,
  output logic              active,
  output logic              irq_set,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_be,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(LANES);

  phase_t            st;
  logic [WORD_W-1:0] desc_q, nxt_q, ptr_q, info_q, word_q, acc_q, flush_addr;
  logic [CNT_W-1:0]  remain;
  logic [LANES-1:0]  be_q;
  logic              have_w, flush;
  logic [LW-1:0]     lane;
  logic [WORD_W-1:0] word_base, lane_word;
  logic [LANES-1:0]  lane_be;
  logic [7:0]        lane_byte;
  logic              xfer, last_byte, tx_beat, rx_beat;

  assign lane      = ptr_q[LW-1:0];
  assign word_base = {ptr_q[WORD_W-1:LW], {LW{1'b0}}};
  assign xfer      = st == ST_XFER;
  assign last_byte = remain == CNT_W'(1);

  chdma_lane #(.LANES(LANES)) u_lane (
    .word_in (word_q),
    .lane    (lane),
    .little  (little),
    .byte_in (rx_data),
    .byte_out(lane_byte),
    .word_out(lane_word),
    .be_out  (lane_be)
  );

  assign tx_valid = xfer && !rx_mode && have_w;
  assign tx_data  = lane_byte;
  assign tx_last  = tx_valid && info_q[F_EOP] && last_byte;
  assign rx_ready = xfer && rx_mode && !flush && remain != '0;
  assign tx_beat  = tx_valid && tx_ready;
  assign rx_beat  = rx_valid && rx_ready;
  assign active   = st != ST_IDLE;
  assign irq_set  = st == ST_WB && mem_ack && info_q[F_IE];
  assign desc_ptr = desc_q;
  assign cur_ptr  = ptr_q;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_q;
    mem_wdata = info_q;
    mem_be    = '1;
    case (st)
      ST_BUF:  mem_req = 1'b1;
      ST_INFO: begin mem_req = 1'b1; mem_addr = desc_q + STEP; end
      ST_NEXT: begin mem_req = 1'b1; mem_addr = desc_q + (STEP << 1); end
      ST_XFER: begin
        if (rx_mode) begin
          mem_req   = flush;
          mem_we    = 1'b1;
          mem_addr  = flush_addr;
          mem_wdata = acc_q;
          mem_be    = be_q;
        end else begin
          mem_req  = !have_w;
          mem_addr = word_base;
        end
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_q + STEP;
        mem_wdata = rx_mode ? (info_q & ~(WORD_W'(1) << F_OWN))
                            : (info_q | (WORD_W'(1) << F_DONE));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      desc_q     <= '0;
      nxt_q      <= '0;
      ptr_q      <= '0;
      info_q     <= '0;
      word_q     <= '0;
      acc_q      <= '0;
      flush_addr <= '0;
      remain     <= '0;
      be_q       <= '0;
      have_w     <= 1'b0;
      flush      <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (next_wr) desc_q <= next_wdata;
          if (start) st <= ST_BUF;
        end
        ST_BUF: if (mem_ack) begin
          ptr_q <= mem_rdata;
          st    <= ST_INFO;
        end
        ST_INFO: if (mem_ack) begin
          info_q <= mem_rdata;
          remain <= mem_rdata[CNT_W-1:0];
          st     <= ST_NEXT;
        end
        ST_NEXT: if (mem_ack) begin
          nxt_q  <= mem_rdata;
          have_w <= 1'b0;
          flush  <= 1'b0;
          be_q   <= '0;
          acc_q  <= '0;
          st     <= (remain == '0) ? ST_WB : ST_XFER;
        end
        ST_XFER: begin
          if (!rx_mode) begin
            if (!have_w && mem_ack) begin
              word_q <= mem_rdata;
              have_w <= 1'b1;
            end
            if (tx_beat) begin
              ptr_q  <= ptr_q + WORD_W'(1);
              remain <= remain - CNT_W'(1);
              if (lane == '1) have_w <= 1'b0;
              if (last_byte) st <= ST_WB;
            end
          end else begin
            if (rx_beat) begin
              acc_q      <= acc_q | lane_word;
              be_q       <= be_q | lane_be;
              flush_addr <= word_base;
              ptr_q      <= ptr_q + WORD_W'(1);
              remain     <= remain - CNT_W'(1);
              if (lane == '1 || last_byte) flush <= 1'b1;
            end
            if (flush && mem_ack) begin
              flush <= 1'b0;
              acc_q <= '0;
              be_q  <= '0;
              if (remain == '0) st <= ST_WB;
            end
          end
        end
        ST_WB: if (mem_ack) begin
          desc_q <= nxt_q;
          st     <= info_q[F_EOC] ? ST_IDLE : ST_BUF;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chdma_top.sv
module chdma_top
  import chdma_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [1:0]        csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_W/8-1:0] mem_be,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data
);
  logic              chan_active, irq_set, start, little, rx_mode, next_wr;
  logic [WORD_W-1:0] desc_ptr, cur_ptr;

  chdma_csr u_csr (
    .clk(clk), .rst_n(rst_n),
    .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .active(chan_active), .irq_set(irq_set),
    .desc_ptr(desc_ptr), .cur_ptr(cur_ptr),
    .start(start), .little(little), .rx_mode(rx_mode),
    .next_wr(next_wr), .irq(irq)
  );

  chdma_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .start(start), .little(little), .rx_mode(rx_mode),
    .next_wr(next_wr), .next_wdata(csr_wdata),
    .desc_ptr(desc_ptr), .cur_ptr(cur_ptr),
    .active(chan_active), .irq_set(irq_set),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );
endmodule

// File: rtl/chdma_chk.sv
module chdma_chk
  import chdma_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_last,
  input logic              rx_ready,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W/8-1:0] mem_be,
  input logic              irq,
  input logic              csr_rd,
  input logic [1:0]        csr_addr,
  input logic              chan_active
);
  a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r5_last_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq && csr_rd && csr_addr == A_CTL && !mem_ack |=> !irq);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_active |-> !mem_req && !tx_valid && !rx_ready);

  a_r4_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  a_r6_write_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != '0);
endmodule

bind chdma_top chdma_chk u_chk (.*);

// File: tb/sim_chdma_top.sv
`timescale 1ns/1ps
module sim_chdma_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        csr_wr = 0, csr_rd = 0;
  logic [1:0]  csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic        irq, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        tx_valid, tx_ready, tx_last, rx_valid, rx_ready;
  logic [7:0]  tx_data, rx_data;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] mem [256];
  logic [7:0]  capd [32];
  logic        capl [32];
  logic [31:0] logv [16];
  logic [7:0]  src [16];
  int ncap, nlog, src_i, src_n = 0;
  int rdy_mode = 0;
  logic rdy_t, cap_clr = 0, tb_we = 0;
  logic [31:0] tb_wa = 0, tb_wd = 0;

  always #5 clk = ~clk;

  chdma_top u0 (.*);

  function automatic logic [7:0] pf(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction
  function automatic logic [31:0] patw(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    return {pf(w), pf(w + 1), pf(w + 2), pf(w + 3)};
  endfunction

  assign mem_rdata = (mem_addr < 32'h100) ? mem[mem_addr[9:2]] : patw(mem_addr);
  assign tx_ready  = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? rdy_t : 1'b0;
  assign rx_valid  = src_i < src_n;
  assign rx_data   = src[src_i[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; ncap <= 0; nlog <= 0; src_i <= 0; rdy_t <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else begin
      rdy_t   <= ~rdy_t;
      mem_ack <= mem_req && !mem_ack;
      if (mem_ack && mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      if (mem_ack && !mem_we && nlog < 16) begin logv[nlog] <= mem_addr; nlog <= nlog + 1; end
      if (tb_we) mem[tb_wa[9:2]] <= tb_wd;
      if (tx_valid && tx_ready && ncap < 32) begin
        capd[ncap] <= tx_data; capl[ncap] <= tx_last; ncap <= ncap + 1;
      end
      if (rx_valid && rx_ready) src_i <= src_i + 1;
      if (cap_clr) begin ncap <= 0; nlog <= 0; src_i <= 0; end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); tb_we = 1; tb_wa = a; tb_wd = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic clear_cap();
    @(negedge clk); cap_clr = 1;
    @(negedge clk); cap_clr = 0;
  endtask

  task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); csr_wr = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); csr_rd = 1; csr_addr = a;
    #1 d = csr_rdata;
    @(negedge clk); csr_rd = 0;
  endtask

  task automatic wait_done(output logic seen);
    logic [31:0] d;
    seen = 0;
    for (int i = 0; i < 4000; i++) begin
      csr_read(2'd0, d);
      seen = seen | d[0];
      if (!d[1]) break;
    end
  endtask

  // len[19:12] off[11:4] le eop ie stall
  localparam logic [19:0] VEC [5] = '{
    {8'd8, 8'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'd5, 8'd1, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'd1, 8'd3, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'd7, 8'd2, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'd4, 8'd0, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, base, info, a;
    logic seen;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk("R1 irq", irq, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rx_ready", rx_ready, 0);
    csr_read(2'd0, d); chk("R1 status", d, 0);
    csr_read(2'd1, d); chk("R1 next ptr", d, 0);
    csr_read(2'd2, d); chk("R1 cur ptr", d, 0);

    // R2 partial start writes
    csr_write(2'd0, 32'h10);
    csr_write(2'd0, 32'h20);
    repeat (4) @(negedge clk);
    chk("R2 no request", mem_req, 0);
    csr_read(2'd0, d); chk("R2 still idle", d, 0);

    // table walk: single transmit descriptors
    for (int k = 0; k < 5; k++) begin
      int len, off;
      logic le, eop, ie;
      len = int'(VEC[k][19:12]); off = int'(VEC[k][11:4]);
      le = VEC[k][3]; eop = VEC[k][2]; ie = VEC[k][1];
      rdy_mode = int'(VEC[k][0]);
      base = 32'h100 + 32'(k) * 32'h40 + 32'(off);
      info = 32'h8000_0000 | (32'(eop) << 30) | (32'(ie) << 29) | 32'(len);
      poke(32'h00, base); poke(32'h04, info); poke(32'h08, 32'h0BAD0);
      clear_cap();
      csr_write(2'd1, 32'h0);
      csr_write(2'd0, 32'h30 | (32'(le) << 1));
      wait_done(seen);
      chk("R4 byte count", 32'(ncap), 32'(len));
      for (int i = 0; i < len; i++) begin
        a = base + 32'(i);
        chk("R4 byte value", {24'h0, capd[i]}, {24'h0, le ? pf({a[31:2], ~a[1:0]}) : pf(a)});
        chk("R5 last flag", {31'h0, capl[i]}, {31'h0, eop && i == len - 1});
      end
      chk("R7 tx writeback", mem[1], info | 32'h8000);
      csr_read(2'd2, d); chk("R11 cur ptr", d, base + 32'(len));
      chk("R9 irq seen", {31'h0, seen}, {31'h0, ie});
      chk("R9 cleared by read", {31'h0, irq}, 0);
      csr_read(2'd1, d); chk("R8 next after end", d, 32'h0BAD0);
    end

    // chain with a zero-length entry, started stalled
    poke(32'h40, 32'h200); poke(32'h44, 32'h3);        poke(32'h48, 32'h50);
    poke(32'h50, 32'h280); poke(32'h54, 32'h2000_0000); poke(32'h58, 32'h60);
    poke(32'h60, 32'h301); poke(32'h64, 32'hC000_0002); poke(32'h68, 32'hAA0);
    rdy_mode = 2;
    clear_cap();
    csr_write(2'd1, 32'h40);
    csr_write(2'd0, 32'h30);
    repeat (20) @(negedge clk);
    chk("R12 stalled valid", {31'h0, tx_valid}, 1);
    chk("R12 stalled data", {24'h0, tx_data}, {24'h0, pf(32'h200)});
    @(negedge clk);
    chk("R12 data held", {24'h0, tx_data}, {24'h0, pf(32'h200)});
    csr_write(2'd1, 32'h7C);
    rdy_mode = 0;
    wait_done(seen);
    chk("R8 chain bytes", 32'(ncap), 5);
    chk("R4 chain b0", {24'h0, capd[0]}, {24'h0, pf(32'h200)});
    chk("R4 chain b2", {24'h0, capd[2]}, {24'h0, pf(32'h202)});
    chk("R8 chain b3", {24'h0, capd[3]}, {24'h0, pf(32'h301)});
    chk("R8 chain b4", {24'h0, capd[4]}, {24'h0, pf(32'h302)});
    chk("R5 no last mid chain", {31'h0, capl[2]}, 0);
    chk("R5 last at end", {31'h0, capl[4]}, 1);
    chk("R7 wb first", mem[32'h44 >> 2], 32'h0000_8003);
    chk("R10 wb zero count", mem[32'h54 >> 2], 32'h2000_8000);
    chk("R7 wb last", mem[32'h64 >> 2], 32'hC000_8002);
    chk("R10 irq from zero count", {31'h0, seen}, 1);
    csr_read(2'd1, d); chk("R11 write while active ignored", d, 32'hAA0);
    csr_read(2'd2, d); chk("R11 cur ptr chain", d, 32'h303);
    chk("R3 fetch word 0", logv[0], 32'h40);
    chk("R3 fetch word 1", logv[1], 32'h44);
    chk("R3 fetch word 2", logv[2], 32'h48);
    chk("R4 data read", logv[3], 32'h200);
    chk("R8 next desc fetch", logv[4], 32'h50);
    chk("R10 no data read", logv[7], 32'h60);
    chk("R3 last desc next word", logv[9], 32'h68);

    // receive, unaligned, big-endian
    src[0] = 8'h11; src[1] = 8'h22; src[2] = 8'h33;
    src[3] = 8'h44; src[4] = 8'h55; src[5] = 8'h66;
    src_n = 6;
    poke(32'h70, 32'h101); poke(32'h74, 32'h8000_4006); poke(32'h78, 32'h0);
    clear_cap();
    csr_write(2'd1, 32'h70);
    csr_write(2'd0, 32'h34);
    wait_done(seen);
    chk("R6 rx word 0", mem[32'h100 >> 2], 32'h0011_2233);
    chk("R6 rx word 1", mem[32'h104 >> 2], 32'h4455_6600);
    chk("R7 rx owner cleared", mem[32'h74 >> 2], 32'h8000_0006);
    chk("R6 no tx beats", 32'(ncap), 0);

    // receive, aligned, little-endian
    src[0] = 8'hA1; src[1] = 8'hA2; src[2] = 8'hA3; src[3] = 8'hA4;
    src_n = 4;
    poke(32'h80, 32'h108); poke(32'h84, 32'hA000_4004); poke(32'h88, 32'h0);
    clear_cap();
    csr_write(2'd1, 32'h80);
    csr_write(2'd0, 32'h36);
    wait_done(seen);
    chk("R6 rx little word", mem[32'h108 >> 2], 32'hA4A3_A2A1);
    chk("R7 rx wb little", mem[32'h84 >> 2], 32'hA000_0004);
    chk("R9 rx irq", {31'h0, seen}, 1);
    csr_read(2'd2, d); chk("R11 rx cur ptr", d, 32'h10C);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule